// File: doc/BRIEF.md
# Multi-Time-Programmable Wiper Setting Store

This block keeps the permanent copy of a digital rheostat's wiper setting. Its store is a small array of setting words, and each word can be written exactly once. A command decoder sends it store, reload and read requests. On a store request, the block copies the live wiper value into the next free word, holds a lock signal for the programming time, and then reports whether the store succeeded. When the logic comes out of reset, the block first hands midscale to the wiper register and then the most recently stored word. A software reload repeats the second step.

Addresses are handed out automatically, starting at 1 and rising by one per accepted store, up to `NUM_WORDS`. Address 0 is reserved and never holds a setting. The host can read the number of the last programmed word and the contents of any word. A reduced-resolution variant keeps only the upper `STORE_W` bits of each setting. The array has its own clear input, which models a fresh, unprogrammed part. Because of that, a logic reset (`rst_n`) acts as a power cycle that leaves the stored words intact.

Top module: `mtp_setting_store`

## Requirements
- R1: In the first cycle after `rst_n` is released, `load_valid` is 1 and `load_value` is midscale (only the top bit set, 512 for 10 bits). In the second cycle, `load_valid` is 1 and `load_value` is the restored setting. In the third cycle, `load_valid` is 0. Out of reset, `busy` and `prog_ok` are 0.
- R2: Accepted stores go to addresses 1, 2, 3 and so on, one per store. `last_addr` shows the address of the most recent store, and shows 0 while nothing has been stored.
- R3: A store request made while `prog_en` is 0 writes nothing and leaves `last_addr` unchanged.
- R4: After an accepted store, `busy` is 1 for exactly `PROG_CYCLES` cycles. While `busy` is 1, store and reload requests have no effect.
- R5: Every store attempt clears `prog_ok`. An accepted store sets it to 1 in the cycle after `busy` drops. A rejected attempt leaves it at 0.
- R6: Once all `NUM_WORDS` words are used, a further store is rejected. Nothing is written, `last_addr` stays at `NUM_WORDS`, and `busy` stays 0.
- R7: A reload request outside programming gives a one-cycle `load_valid` in the next cycle. The value is the most recently stored word, or midscale if nothing has been stored.
- R8: `rd_data` returns the word stored at `rd_addr`. Address 0, addresses above `NUM_WORDS`, and unwritten words all read as 0.
- R9: When `STORE_W` is less than `DATA_W`, a word keeps the upper `STORE_W` bits of the wiper value. Reads and restores return those bits with the low bits set to zero.
- R10: Pulsing `rst_n` while `arr_clr_n` stays high keeps every stored word. The restore value after that reset is the last stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low logic reset; releasing it runs the power-up restore |
| arr_clr_n | input | 1 | Active-low clear of the setting array (blank part) |
| prog_en | input | 1 | Program-enable control bit |
| store_req | input | 1 | Store the wiper value into the next free word |
| reload_req | input | 1 | Software reset: reload the wiper from the store |
| wiper_in | input | DATA_W | Live wiper register value |
| rd_addr | input | ADDR_W | Address of the word to read back |
| rd_data | output | DATA_W | Word at `rd_addr`, left-aligned |
| last_addr | output | ADDR_W | Address of the last programmed word |
| busy | output | 1 | Programming in progress; interface locked |
| prog_ok | output | 1 | Last store attempt succeeded |
| load_valid | output | 1 | Load `load_value` into the wiper register |
| load_value | output | DATA_W | Value for the wiper register |

## Verification
The array is filled word by word with settings produced by an arithmetic formula, so neighbouring words differ in many bits. A full read sweep over all 64 addresses then shows whether allocation skipped, repeated or overwrote a word, and confirms that address 0 and out-of-range addresses read as empty. Store attempts are made with the enable low, during programming, and after the array is full; these separate the three ways a store can be rejected from an accepted store. Restores are compared with a blank array and with a programmed one, both after a logic reset and after a software reload. A narrow-word instance takes the same stimulus, so its truncated results can be compared directly with the full-width ones.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [1:0] {
    ST_BOOT_MID = 2'd0,
    ST_BOOT_RES = 2'd1,
    ST_RUN      = 2'd2
  } mtp_state_t;

  // true when a is a usable setting address in 1..n
  function automatic logic addr_in_range(input int a, input int n);
    return (a >= 1) && (a <= n);
  endfunction
endpackage

// File: rtl/mtp_prog_timer.sv
module mtp_prog_timer #(
  parameter int PROG_CYCLES = 20,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain <= '0;
    else if (start)     remain <= CW'(PROG_CYCLES);
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/mtp_fuse_array.sv
module mtp_fuse_array #(
  parameter int NUM_WORDS = 50,
  parameter int STORE_W   = 10,
  parameter int ADDR_W    = 6
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               wr_en,
  input  logic [STORE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [STORE_W-1:0] rd_data,
  output logic [ADDR_W-1:0]  last_addr,
  output logic [STORE_W-1:0] last_data,
  output logic               full
);
  logic [STORE_W-1:0] word [NUM_WORDS];
  logic [ADDR_W-1:0]  next_addr;

  assign next_addr = last_addr + 1'b1;
  assign full      = (last_addr == ADDR_W'(NUM_WORDS));

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)     last_addr <= '0;
    else if (wr_en) last_addr <= next_addr;
  end

  // word g holds address g+1; each is written once when its address comes up
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)                                       word[g] <= '0;
      else if (wr_en && next_addr == ADDR_W'(g + 1))    word[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data   = '0;
    last_data = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_addr   == ADDR_W'(i + 1)) rd_data   = word[i];
      if (last_addr == ADDR_W'(i + 1)) last_data = word[i];
    end
    if (!mtp_pkg::addr_in_range(int'(rd_addr), NUM_WORDS)) rd_data = '0;
  end

  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!clr_n)
    wr_en |-> !full);
  a_r2_word_frozen: assert property (@(posedge clk) disable iff (!clr_n)
    (!wr_en && rd_addr == last_addr && last_addr != '0) |=> $stable(last_data));
endmodule

// File: rtl/mtp_setting_store.sv
module mtp_setting_store #(
  parameter int DATA_W      = 10,
  parameter int STORE_W     = 10,
  parameter int NUM_WORDS   = 50,
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_clr_n,
  input  logic              prog_en,
  input  logic              store_req,
  input  logic              reload_req,
  input  logic [DATA_W-1:0] wiper_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] last_addr,
  output logic              busy,
  output logic              prog_ok,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_value
);
  import mtp_pkg::*;

  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  // left-align a stored word into a wiper-width value
  function automatic logic [DATA_W-1:0] widen(input logic [STORE_W-1:0] w);
    logic [DATA_W-1:0] r;
    r = '0;
    r[DATA_W-1 -: STORE_W] = w;
    return r;
  endfunction

  mtp_state_t         state;
  logic               full;
  logic               wr_en;
  logic               store_attempt;
  logic               reload_take;
  logic               prog_done;
  logic [STORE_W-1:0] arr_rd;
  logic [STORE_W-1:0] arr_last;
  logic [DATA_W-1:0]  restore_val;

  assign store_attempt = store_req && (state == ST_RUN) && !busy;
  assign wr_en         = store_attempt && prog_en && !full;
  assign reload_take   = reload_req && (state == ST_RUN) && !busy;
  assign restore_val   = (last_addr == '0) ? MID : widen(arr_last);
  assign rd_data       = widen(arr_rd);

  mtp_fuse_array #(
    .NUM_WORDS(NUM_WORDS), .STORE_W(STORE_W), .ADDR_W(ADDR_W)
  ) u_array (
    .clk(clk), .clr_n(arr_clr_n), .wr_en(wr_en),
    .wr_data(wiper_in[DATA_W-1 -: STORE_W]),
    .rd_addr(rd_addr), .rd_data(arr_rd),
    .last_addr(last_addr), .last_data(arr_last), .full(full)
  );

  mtp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wr_en), .busy(busy), .done(prog_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_BOOT_MID;
      load_valid <= 1'b0;
      load_value <= MID;
      prog_ok    <= 1'b0;
    end else begin
      load_valid <= 1'b0;
      unique case (state)
        ST_BOOT_MID: begin
          load_valid <= 1'b1;
          load_value <= MID;
          state      <= ST_BOOT_RES;
        end
        ST_BOOT_RES: begin
          load_valid <= 1'b1;
          load_value <= restore_val;
          state      <= ST_RUN;
        end
        default: begin
          if (reload_take) begin
            load_valid <= 1'b1;
            load_value <= restore_val;
          end
        end
      endcase
      if (store_attempt)  prog_ok <= 1'b0;
      else if (prog_done) prog_ok <= 1'b1;
    end
  end

  a_r1_boot_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BOOT_MID) |=> (load_valid && load_value == MID));
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n || !arr_clr_n)
    wr_en |=> (last_addr == $past(last_addr) + 1'b1));
  a_r3_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req && !prog_en) |-> !wr_en);
  a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!wr_en && !reload_take));
  a_r5_ok_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> prog_ok);
  a_r6_full_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (store_attempt && full) |=> (!prog_ok && !busy));
  a_r7_reload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reload_take |=> (load_valid && load_value == $past(restore_val)));
endmodule

// File: tb/test_mtp_setting_store.sv
module test_mtp_setting_store;
  localparam int DW = 10;
  localparam int NW = 50;
  localparam int AW = 6;
  localparam int PC = 20;
  localparam int MID = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, arr_clr_n = 1'b0, prog_en = 1'b0;
  logic store_req = 1'b0, reload_req = 1'b0;
  logic [DW-1:0] wiper_in = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data, load_value, n_rd_data, n_load_value, n_restore_val;
  logic [AW-1:0] last_addr, n_last_addr;
  logic busy, prog_ok, load_valid, n_busy, n_prog_ok, n_load_valid;

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  mtp_setting_store #(.DATA_W(DW), .STORE_W(DW), .NUM_WORDS(NW), .ADDR_W(AW),
    .PROG_CYCLES(PC)) i_mtp_setting_store (
    .clk(clk), .rst_n(rst_n), .arr_clr_n(arr_clr_n), .prog_en(prog_en),
    .store_req(store_req), .reload_req(reload_req), .wiper_in(wiper_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .last_addr(last_addr), .busy(busy),
    .prog_ok(prog_ok), .load_valid(load_valid), .load_value(load_value));

  mtp_setting_store #(.DATA_W(DW), .STORE_W(8), .NUM_WORDS(NW), .ADDR_W(AW),
    .PROG_CYCLES(PC)) i_mtp_setting_store_narrow (
    .clk(clk), .rst_n(rst_n), .arr_clr_n(arr_clr_n), .prog_en(prog_en),
    .store_req(store_req), .reload_req(reload_req), .wiper_in(wiper_in),
    .rd_addr(rd_addr), .rd_data(n_rd_data), .last_addr(n_last_addr), .busy(n_busy),
    .prog_ok(n_prog_ok), .load_valid(n_load_valid), .load_value(n_load_value));

  assign n_restore_val = '0;

  function automatic int pattern(input int n);
    return (n * 373 + 91) % 1024;
  endfunction

  function automatic int narrow(input int v);
    return (v / 4) * 4;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse store; returns number of busy cycles seen afterwards
  task automatic do_store(input int val, output int nbusy);
    wiper_in  = DW'(val);
    store_req = 1'b1;
    @(negedge clk);
    store_req = 1'b0;
    nbusy = 0;
    while (busy && nbusy < 1000) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic check_boot(input string req, input int restored, input int n_restored);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req, " boot mid valid"}, int'(load_valid), 1);
    chk({req, " boot mid value"}, int'(load_value), MID);
    @(negedge clk);
    chk({req, " restore valid"}, int'(load_valid), 1);
    chk({req, " restore value"}, int'(load_value), restored);
    chk("R9 narrow restore", int'(n_load_value), n_restored);
    @(negedge clk);
    chk({req, " load_valid drops"}, int'(load_valid), 0);
    chk({req, " busy idle"}, int'(busy), 0);
    chk({req, " prog_ok idle"}, int'(prog_ok), 0);
  endtask

  task automatic do_reload(input string req, input int exp, input int n_exp);
    reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    chk({req, " reload valid"}, int'(load_valid), 1);
    chk({req, " reload value"}, int'(load_value), exp);
    chk("R9 narrow reload", int'(n_load_value), n_exp);
    @(negedge clk);
    chk({req, " reload one cycle"}, int'(load_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    arr_clr_n = 1'b1;
    // R1: blank array restores midscale twice
    check_boot("R1", MID, MID);
    chk("R2 last_addr blank", int'(last_addr), 0);
    // R7 blank reload
    do_reload("R7 blank", MID, MID);
    // R8 empty reads
    for (int a = 0; a < 64; a++) begin
      rd_addr = AW'(a);
      #1 chk("R8 blank read", int'(rd_data), 0);
    end
    // R3 store with enable low
    do_store(100, nb);
    chk("R3 no busy", nb, 0);
    chk("R3 last_addr unchanged", int'(last_addr), 0);
    chk("R5 prog_ok after disabled store", int'(prog_ok), 0);
    rd_addr = AW'(1);
    #1 chk("R3 word 1 unwritten", int'(rd_data), 0);

    // R4/R5 first accepted store, with requests during busy
    prog_en = 1'b1;
    wiper_in = DW'(pattern(1));
    store_req = 1'b1;
    @(negedge clk);
    store_req = 1'b0;
    chk("R5 prog_ok cleared on accept", int'(prog_ok), 0);
    chk("R2 first address", int'(last_addr), 1);
    nb = 0;
    while (busy && nb < 1000) begin
      nb++;
      if (nb == 5) begin
        store_req = 1'b1;
        reload_req = 1'b1;
        wiper_in = DW'(7);
      end else begin
        store_req = 1'b0;
        reload_req = 1'b0;
      end
      @(negedge clk);
      chk("R4 no load while busy", int'(load_valid), 0);
    end
    store_req = 1'b0;
    reload_req = 1'b0;
    chk("R4 busy length", nb, PC);
    chk("R4 store ignored while busy", int'(last_addr), 1);
    chk("R5 prog_ok set", int'(prog_ok), 1);
    rd_addr = AW'(1);
    #1 chk("R8 read word 1", int'(rd_data), pattern(1));
    chk("R9 narrow word 1", int'(n_rd_data), narrow(pattern(1)));
    do_reload("R7", pattern(1), narrow(pattern(1)));

    // R10 power cycle keeps the array
    rst_n = 1'b0;
    check_boot("R10", pattern(1), narrow(pattern(1)));
    chk("R10 last_addr kept", int'(last_addr), 1);

    // fill the rest
    for (int n = 2; n <= NW; n++) begin
      do_store(pattern(n), nb);
      chk("R4 busy length", nb, PC);
      chk("R2 sequential address", int'(last_addr), n);
      chk("R9 narrow address", int'(n_last_addr), n);
      chk("R5 prog_ok", int'(prog_ok), 1);
    end
    for (int a = 0; a < 64; a++) begin
      rd_addr = AW'(a);
      #1;
      chk("R8 sweep read", int'(rd_data), (a >= 1 && a <= NW) ? pattern(a) : 0);
      chk("R9 sweep narrow", int'(n_rd_data), (a >= 1 && a <= NW) ? narrow(pattern(a)) : 0);
    end

    // R6 store when full
    do_store(3, nb);
    chk("R6 no busy when full", nb, 0);
    chk("R6 last_addr held", int'(last_addr), NW);
    chk("R6 prog_ok cleared", int'(prog_ok), 0);
    rd_addr = AW'(NW);
    #1 chk("R6 last word intact", int'(rd_data), pattern(NW));
    do_reload("R7 full", pattern(NW), narrow(pattern(NW)));

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule